// File: doc/BRIEF.md
# Two-Wire Byte-Addressed Memory Slave Controller

This block is the bus-facing controller of a serial byte memory that sits on a two-wire I2C bus. It watches the clock and data lines through synchronizers running on the system clock. It finds START and STOP conditions and compares the incoming 7-bit device address with its own. A write transfer carries a two-byte memory address and then any number of data bytes. A read transfer returns bytes from an internal address pointer, either one byte or a sequential stream. The slave drives the bus only by pulling SDA low through an output-enable.

The memory pointer is kept between transfers. A read without a preceding address phase therefore continues from the location after the last byte that was written or read. The pointer wraps from the top of the array back to zero. The master can close a read in four legal ways. After the last data bit the master may NACK and then send STOP, or NACK and then send a repeated START. It may also send STOP, or a repeated START, in place of the acknowledge clock. The block connects to a plain synchronous memory port. A write is a one-cycle strobe. A read is a one-cycle request, and its data comes back on the following cycle.

Top module: `i2c_mem_slave`

## Requirements
- R1: While reset is held, and after it is released with the bus idle, `sdaOe`, `memWe` and `memRe` are all low.
- R2: A START followed by a byte whose upper seven bits equal `DEV_ADDR` is acknowledged (SDA low during the 9th clock). Any other address is not acknowledged. No byte after it is acknowledged and no memory access happens until the next START.
- R3: In a write (address byte bit 0 = 0), the slave acknowledges the high address byte, the low address byte and every data byte. Each data byte produces exactly one `memWe` pulse carrying that byte and the current pointer.
- R4: The pointer is loaded from the low 13 bits of {high byte, low byte}. Bits 15..13 of the received address are ignored.
- R5: The pointer advances by one after every data byte written and every byte fetched for reading. It wraps from 1FFFh to 0000h.
- R6: In a read (address byte bit 0 = 1), the byte at the pointer is shifted out MSB first, starting in the clock that follows the address acknowledge.
- R7: When the master acknowledges a read byte (SDA low in the 9th clock), the slave fetches and sends the next sequential byte.
- R8: When the master NACKs a read byte and then gives STOP or a repeated START, the slave leaves SDA released and fetches nothing more.
- R9: A STOP or a repeated START given in the 9th clock of a read byte ends the read. SDA is released and no further byte is fetched, so the pointer stays just past the last byte sent.
- R10: The pointer keeps its value between transfers. A read with no address phase starts at the location after the last access.
- R11: A START or STOP inside a byte aborts the transfer. The partial byte is not written and the pointer is unchanged.
- R12: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Pull SDA low when 1, release when 0 |
| memAddr | output | ADDR_W | Memory location for the current access |
| memWe | output | 1 | One-cycle write strobe |
| memWdata | output | 8 | Byte to write |
| memRe | output | 1 | One-cycle read request |
| memRdata | input | 8 | Read byte, valid the cycle after `memRe` |

## Verification
The master's 9th clock of a read byte is where the decision to fetch the next byte meets a terminating STOP or repeated START. The bench drives STOP, or a repeated START, in place of the acknowledge. It judges the result three ways: the count of read requests, SDA being released, and the byte returned by the next current-address read. The pointer increment also meets the wrap from 1FFFh to 0000h. This is provoked by multi-byte writes and by sequential reads that cross the top of memory. It is judged by the addresses logged at the memory port.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic loadHi;    // keep high address byte
    logic loadLo;    // load pointer from both address bytes
    logic write;     // commit received byte to memory
    logic fetch;     // request a byte from memory
    logic loadTx;    // take returned byte into transmit shifter
    logic shiftTx;   // advance transmit shifter
  } dpStrobe_t;

  // bus observations from the datapath to the control FSM
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sclLvl;
    logic sdaLvl;
  } busEvt_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACK,
    ST_LOADW,
    ST_TX,
    ST_MACK,
    ST_RDNEXT,
    ST_WAIT
  } ctrlState_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_HI,
    RX_LO,
    RX_DATA
  } rxKind_t;

endpackage

// File: rtl/i2c_mem_sync.sv
module i2c_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout,
  output logic doutPrev
);
  // the bus idles high, so every stage resets to 1
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-1:0], din};
  end

  assign dout     = chain[STAGES-1];
  assign doutPrev = chain[STAGES];
endmodule

// File: rtl/i2c_mem_datapath.sv
module i2c_mem_datapath
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  input  logic [7:0]        memRdata,
  output busEvt_t           evt,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata
);
  localparam int HI_BITS  = ADDR_W - 8;
  localparam int N_LINES  = 2;
  localparam int SCL_IDX  = 0;
  localparam int SDA_IDX  = 1;

  logic [N_LINES-1:0] lineIn, lineNow, lineOld;
  assign lineIn = {sdaIn, sclIn};

  for (genvar g = 0; g < N_LINES; g++) begin : gLine
    i2c_mem_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk      (clk),
      .rstN     (rstN),
      .din      (lineIn[g]),
      .dout     (lineNow[g]),
      .doutPrev (lineOld[g])
    );
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = lineNow[SCL_IDX];
  assign sclOld = lineOld[SCL_IDX];
  assign sdaNow = lineNow[SDA_IDX];
  assign sdaOld = lineOld[SDA_IDX];

  always_comb begin
    evt.sclRise   = sclNow & ~sclOld;
    evt.sclFall   = ~sclNow & sclOld;
    evt.startSeen = sclNow & sclOld & ~sdaNow & sdaOld;
    evt.stopSeen  = sclNow & sclOld & sdaNow & ~sdaOld;
    evt.sclLvl    = sclNow;
    evt.sdaLvl    = sdaNow;
  end

  logic [7:0]         rxShift;
  logic [7:0]         txShift;
  logic [HI_BITS-1:0] hiBits;
  logic [ADDR_W-1:0]  addrLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.shiftIn) begin
      rxShift <= {rxShift[6:0], sdaNow};
    end
  end

  // only the bits that reach the pointer are kept from the high byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiBits <= '0;
    end else if (strb.loadHi) begin
      hiBits <= rxShift[HI_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
    end else if (strb.loadLo) begin
      addrLatch <= {hiBits, rxShift};
    end else if (strb.write || strb.fetch) begin
      addrLatch <= addrLatch + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (strb.loadTx) begin
      txShift <= memRdata;
    end else if (strb.shiftTx) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign rxByte   = rxShift;
  assign txBit    = txShift[7];
  assign memAddr  = addrLatch;
  assign memWdata = rxShift;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.write || strb.fetch || strb.loadLo) |=> $stable(addrLatch)); // R10

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.write || strb.fetch) && !strb.loadLo && (addrLatch == '1)) |=> (addrLatch == '0)); // R5

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strb,
  output logic       sdaOe
);
  localparam logic [2:0] LAST_BIT = 3'd7;

  ctrlState_t state, nState;
  rxKind_t    kind, nKind;
  logic [2:0] bitCnt, nCnt;
  logic       rwBit, nRw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kind   <= RX_DEV;
      bitCnt <= '0;
      rwBit  <= 1'b0;
    end else begin
      state  <= nState;
      kind   <= nKind;
      bitCnt <= nCnt;
      rwBit  <= nRw;
    end
  end

  always_comb begin
    nState = state;
    nKind  = kind;
    nCnt   = bitCnt;
    nRw    = rwBit;
    strb   = '0;

    unique case (state)
      ST_IDLE: ;
      ST_RX: begin
        if (evt.sclRise) begin
          strb.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) nState = ST_RXEND;
          else                    nCnt   = bitCnt + 3'd1;
        end
      end
      ST_RXEND: begin
        if (evt.sclFall) begin
          nState = ST_ACK;
          unique case (kind)
            RX_DEV: begin
              if (rxByte[7:1] == DEV_ADDR) nRw = rxByte[0];
              else                         nState = ST_IDLE;
            end
            RX_HI:   strb.loadHi = 1'b1;
            RX_LO:   strb.loadLo = 1'b1;
            RX_DATA: strb.write  = 1'b1;
            default: nState = ST_IDLE;
          endcase
        end
      end
      ST_ACK: begin
        if (evt.sclFall) begin
          if (rwBit) begin
            strb.fetch = 1'b1;
            nState     = ST_LOADW;
          end else begin
            nState = ST_RX;
            nCnt   = '0;
            unique case (kind)
              RX_DEV:  nKind = RX_HI;
              RX_HI:   nKind = RX_LO;
              default: nKind = RX_DATA;
            endcase
          end
        end
      end
      ST_LOADW: begin
        strb.loadTx = 1'b1;
        nState      = ST_TX;
        nCnt        = '0;
      end
      ST_TX: begin
        if (evt.sclFall) begin
          if (bitCnt == LAST_BIT) begin
            nState = ST_MACK;
          end else begin
            strb.shiftTx = 1'b1;
            nCnt         = bitCnt + 3'd1;
          end
        end
      end
      ST_MACK: begin
        if (evt.sclRise) nState = evt.sdaLvl ? ST_WAIT : ST_RDNEXT;
      end
      ST_RDNEXT: begin
        if (evt.sclFall) begin
          strb.fetch = 1'b1;
          nState     = ST_LOADW;
        end
      end
      ST_WAIT: ;
      default: nState = ST_IDLE;
    endcase

    // bus conditions override whatever the byte engine was doing
    if (evt.startSeen) begin
      strb   = '0;
      nState = ST_RX;
      nKind  = RX_DEV;
      nCnt   = '0;
      nRw    = 1'b0;
    end else if (evt.stopSeen) begin
      strb   = '0;
      nState = ST_IDLE;
    end
  end

  assign sdaOe = (state == ST_ACK) || ((state == ST_TX) && !txBit);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !evt.sclLvl); // R12

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopSeen |=> !sdaOe); // R11

  AST_NO_ACK_FOREIGN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RXEND && kind == RX_DEV && evt.sclFall && !evt.startSeen
     && rxByte[7:1] != DEV_ADDR) |=> !sdaOe); // R2

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.write && strb.fetch)); // R3

  AST_FETCH_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetch |-> rwBit); // R6

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              memRe,
  input  logic [7:0]        memRdata
);
  dpStrobe_t  strb;
  busEvt_t    evt;
  logic [7:0] rxByte;
  logic       txBit;

  i2c_mem_datapath #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strb     (strb),
    .memRdata (memRdata),
    .evt      (evt),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  i2c_mem_ctrl #(
    .DEV_ADDR (DEV_ADDR)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (evt),
    .rxByte (rxByte),
    .txBit  (txBit),
    .strb   (strb),
    .sdaOe  (sdaOe)
  );

  assign memWe = strb.write;
  assign memRe = strb.fetch;
endmodule

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 8;
  localparam int         WATCHDOG   = 150000;
  localparam logic [6:0] DEV        = 7'h50;
  localparam int         N_VEC      = 8;

  // {read, address[15:0], data}
  localparam logic [24:0] VEC [N_VEC] = '{
    {1'b0, 16'h0010, 8'hA5},
    {1'b0, 16'h0011, 8'h3C},
    {1'b0, 16'h1FFF, 8'h7E},
    {1'b0, 16'hE123, 8'hC9},
    {1'b1, 16'h0010, 8'hA5},
    {1'b1, 16'h1FFF, 8'h7E},
    {1'b1, 16'h0123, 8'hC9},
    {1'b1, 16'h0011, 8'h3C}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mScl = 1'b1;
  logic        mSda = 1'b1;
  logic        sdaOe;
  logic        sdaBus;
  logic [12:0] memAddr;
  logic        memWe, memRe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = 8'h00;

  int vecCnt = 0;
  int failCnt = 0;
  int wrCnt = 0;
  int reCnt = 0;
  int oeSclHigh = 0;
  logic oePrev = 1'b0;
  logic [7:0]  bmem [256];
  logic [12:0] wrAddrLog [8];
  logic [7:0]  wrDataLog [8];

  assign sdaBus = mSda & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_slave i_i2c_mem_slave (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (mScl),
    .sdaIn    (sdaBus),
    .sdaOe    (sdaOe),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .memRe    (memRe),
    .memRdata (memRdata)
  );

  // synchronous memory model with one cycle read latency
  always @(posedge clk) begin
    if (memWe) begin
      bmem[memAddr[7:0]]   <= memWdata;
      wrAddrLog[wrCnt % 8] <= memAddr;
      wrDataLog[wrCnt % 8] <= memWdata;
      wrCnt <= wrCnt + 1;
    end
    if (memRe) begin
      memRdata <= bmem[memAddr[7:0]];
      reCnt    <= reCnt + 1;
    end
  end

  // R12: record any change of the drive while the master holds SCL high
  always @(negedge clk) begin
    if (rstN && (sdaOe !== oePrev) && mScl) oeSclHigh <= oeSclHigh + 1;
    oePrev <= sdaOe;
  end

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    mSda = b;    tick(Q);
    mScl = 1'b1; tick(2*Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic b);
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    b = sdaBus;  tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(a);
    ack = ~a;
  endtask

  task automatic recvByte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
  endtask

  task automatic setPtr(input logic [15:0] a, input string req);
    logic ack;
    busStart();
    sendByte({DEV, 1'b0}, ack); checkEq(req, ack, 1);
    sendByte(a[15:8], ack);     checkEq(req, ack, 1);
    sendByte(a[7:0], ack);      checkEq(req, ack, 1);
  endtask

  task automatic readStart(input string req);
    logic ack;
    busStart();
    sendByte({DEV, 1'b1}, ack); checkEq(req, ack, 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    vecCnt++;
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin
    logic        ack;
    logic [7:0]  got;
    int          n0;
    int          r0;

    // R1 during and after reset
    tick(5);
    checkEq("R1", sdaOe, 0);
    checkEq("R1", memWe, 0);
    checkEq("R1", memRe, 0);
    rstN = 1'b1;
    tick(5);
    checkEq("R1", sdaOe, 0);
    checkEq("R1", {memWe, memRe}, 0);

    // vector table: random writes then random reads
    for (int i = 0; i < N_VEC; i++) begin
      logic        isRd;
      logic [15:0] a;
      logic [7:0]  d;
      isRd = VEC[i][24];
      a    = VEC[i][23:8];
      d    = VEC[i][7:0];
      if (!isRd) begin
        setPtr(a, "R3");
        n0 = wrCnt;
        sendByte(d, ack); checkEq("R3", ack, 1);
        busStop(); tick(Q);
        checkEq("R3", wrCnt - n0, 1);
        checkEq("R4", wrAddrLog[n0 % 8], {19'd0, a[12:0]});
        checkEq("R3", wrDataLog[n0 % 8], d);
      end else begin
        setPtr(a, "R6");
        readStart("R6");
        recvByte(got);
        sendBit(1'b1);
        busStop(); tick(Q);
        checkEq("R6", got, d);
      end
    end

    // R2 foreign device address
    n0 = wrCnt;
    r0 = reCnt;
    busStart();
    sendByte({7'h51, 1'b0}, ack); checkEq("R2", ack, 0);
    sendByte(8'h00, ack);         checkEq("R2", ack, 0);
    sendByte(8'h10, ack);
    sendByte(8'hEE, ack);
    busStop(); tick(Q);
    checkEq("R2", wrCnt - n0, 0);
    busStart();
    sendByte({7'h51, 1'b1}, ack); checkEq("R2", ack, 0);
    recvByte(got);                checkEq("R2", got, 8'hFF);
    sendBit(1'b1);
    busStop(); tick(Q);
    checkEq("R2", reCnt - r0, 0);

    // R3 / R5 multi-byte write across the top of memory
    setPtr(16'h1FFE, "R3");
    n0 = wrCnt;
    for (int k = 0; k < 5; k++) begin
      sendByte(8'((k + 1) * 8'h11), ack);
      checkEq("R3", ack, 1);
    end
    busStop(); tick(Q);
    checkEq("R3", wrCnt - n0, 5);
    for (int k = 0; k < 5; k++) begin
      checkEq("R5", wrAddrLog[(n0 + k) % 8], (32'h1FFE + k) & 32'h1FFF);
      checkEq("R3", wrDataLog[(n0 + k) % 8], (k + 1) * 8'h11);
    end

    // R10 current-address read, R7 sequential, R8 NACK then STOP
    setPtr(16'h0001, "R10");
    busStop(); tick(Q);
    r0 = reCnt;
    readStart("R10");
    recvByte(got); checkEq("R10", got, 8'h44);
    sendBit(1'b0);
    recvByte(got); checkEq("R7", got, 8'h55);
    sendBit(1'b1);
    busStop(); tick(Q);
    checkEq("R8", sdaOe, 0);
    checkEq("R8", reCnt - r0, 2);

    // R5 sequential read across the wrap
    setPtr(16'h1FFF, "R5");
    readStart("R5");
    recvByte(got); checkEq("R5", got, 8'h22);
    sendBit(1'b0);
    recvByte(got); checkEq("R5", got, 8'h33);
    sendBit(1'b0);
    recvByte(got); checkEq("R7", got, 8'h44);
    sendBit(1'b1);
    busStop(); tick(Q);

    // R8 NACK then repeated START
    setPtr(16'h1FFE, "R8");
    r0 = reCnt;
    readStart("R8");
    recvByte(got); checkEq("R8", got, 8'h11);
    sendBit(1'b1);
    busStart();
    checkEq("R8", sdaOe, 0);
    checkEq("R8", reCnt - r0, 1);
    sendByte({DEV, 1'b1}, ack); checkEq("R8", ack, 1);
    recvByte(got); checkEq("R8", got, 8'h22);
    sendBit(1'b1);
    busStop(); tick(Q);

    // R9 STOP in the 9th clock
    setPtr(16'h0000, "R9");
    r0 = reCnt;
    readStart("R9");
    recvByte(got); checkEq("R9", got, 8'h33);
    busStop(); tick(Q);
    checkEq("R9", sdaOe, 0);
    checkEq("R9", reCnt - r0, 1);
    readStart("R9");
    recvByte(got); checkEq("R9", got, 8'h44);
    sendBit(1'b1);
    busStop(); tick(Q);

    // R9 repeated START in the 9th clock (pointer now 0002)
    r0 = reCnt;
    readStart("R9");
    recvByte(got); checkEq("R9", got, 8'h55);
    busStart();
    checkEq("R9", sdaOe, 0);
    checkEq("R9", reCnt - r0, 1);
    sendByte({DEV, 1'b0}, ack); checkEq("R9", ack, 1);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    readStart("R9");
    recvByte(got); checkEq("R9", got, 8'h33);
    sendBit(1'b1);
    busStop(); tick(Q);

    // R11 STOP inside a data byte
    setPtr(16'h0010, "R11");
    n0 = wrCnt;
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStop(); tick(Q);
    checkEq("R11", wrCnt - n0, 0);
    readStart("R11");
    recvByte(got); checkEq("R11", got, 8'hA5);
    sendBit(1'b1);
    busStop(); tick(Q);

    // R11 START inside a data byte
    setPtr(16'h0011, "R11");
    n0 = wrCnt;
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    readStart("R11");
    checkEq("R11", wrCnt - n0, 0);
    recvByte(got); checkEq("R11", got, 8'h3C);
    sendBit(1'b1);
    busStop(); tick(Q);

    checkEq("R12", oeSclHigh, 0);

    summary();
    $finish;
  end
endmodule